// File: doc/BRIEF.md
# PCM Serial Port with Robbed-Bit Signaling

This block is the digital edge of one fixed-rate PCM voice channel. It has separate transmit and receive master clocks, and each side has its own 8 kHz frame-sync input. Each sync pulse opens an 8-bit time slot. On the transmit side the block loads a parallel sample and shifts it out MSB first. A slot strobe is high for the eight bit periods. On the receive side the block assembles the serial bits into a parallel word and flags it with a one-cycle valid pulse. Both parallel sides connect to a converter model.

The width of the sync pulse sets the frame type. A pulse one clock wide opens a normal frame. A pulse two clocks wide opens a signaling frame. In a signaling frame the eighth transmitted bit carries a signaling input in place of the sample LSB. The eighth received bit is latched as the received signaling state, which is held on an output until the next signaling frame.

After the first sync pulse, each side keeps a frame counter. The counter length is chosen by a rate input: 192, 193 or 256 clocks per frame. If a sync pulse does not arrive, the side opens a normal frame by itself at the expected time.

Top module: `pcm_sig_port`

## Requirements
- R1: During reset, and after reset until the first sync pulse, all outputs are low and no slot opens.
- R2: A frame opens on the first rising clock edge at which sync is sampled high after being low. At that edge the sample and the signaling input are captured, and `tx_data_o` carries sample bit 7 (MSB). The next seven rising edges put bits 6 down to 0 on `tx_data_o`.
- R3: `tx_slot_o` is high for exactly 8 consecutive cycles, aligned with the eight transmitted bits. `tx_data_o` is low whenever `tx_slot_o` is low.
- R4: A frame is a signaling frame only when sync is sampled high on exactly two consecutive rising edges. A pulse one edge wide, or three or more edges wide, gives a normal frame.
- R5: In a signaling frame the eighth transmitted bit is the captured signaling input instead of sample bit 0.
- R6: Receive bits are sampled on the falling edges that follow the first eight rising edges of a frame. The first bit received lands in bit 7 of the word. `rx_word_o` updates and `rx_valid_o` is high for exactly one cycle starting at the ninth rising edge, counting the opening edge as the first.
- R7: `rx_sig_o` keeps its value until the ninth rising edge of a signaling frame. At that edge it takes the eighth received bit. Normal frames leave it unchanged.
- R8: `rate_sel_i` sets the frame length: 0 gives 192 clocks, 1 gives 193 clocks, 2 or 3 give 256 clocks.
- R9: Once a side has seen a sync pulse, a missing sync opens a normal frame exactly one frame length after the previous frame opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk_i | input | 1 | Transmit master clock |
| tx_rst_ni | input | 1 | Transmit async reset, active low |
| rx_clk_i | input | 1 | Receive master clock |
| rx_rst_ni | input | 1 | Receive async reset, active low |
| rate_sel_i | input | 2 | Frame length select (static) |
| tx_sync_i | input | 1 | Transmit frame sync |
| tx_sample_i | input | 8 | Parallel sample to transmit |
| tx_sig_i | input | 1 | Signaling bit to transmit |
| tx_data_o | output | 1 | Serial transmit data |
| tx_slot_o | output | 1 | High during the 8 transmit bit periods |
| rx_sync_i | input | 1 | Receive frame sync |
| rx_data_i | input | 1 | Serial receive data |
| rx_word_o | output | 8 | Last received word |
| rx_valid_o | output | 1 | One-cycle pulse when a new word is presented |
| rx_sig_o | output | 1 | Held received signaling bit |

## Verification
The first transmit bit and the rising slot strobe appear one register after the edge that sees sync. The bench therefore samples them at the falling edge just after that edge. Each later bit is sampled at one falling edge per cycle.

The loopback receive path adds a falling-edge capture stage and then the output register. As a result, the word, the valid pulse and the signaling update are checked at the falling edge after the ninth rising edge. The signaling output is also checked one cycle earlier to confirm that it still holds its old value.

Frame-length and self-timed-frame checks look at the falling edge just before the expected start, where the strobe must be low. They then look at the falling edge just after it, where the strobe must be high.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic [1:0] {
    RATE_SHORT = 2'd0,
    RATE_EXTRA = 2'd1,
    RATE_LONG  = 2'd2,
    RATE_LONG2 = 2'd3
  } rate_e;
endpackage

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl
  import pcm_port_pkg::*;
#(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned LEN_A  = 192,
  parameter int unsigned LEN_B  = 193,
  parameter int unsigned LEN_C  = 256,
  localparam int unsigned IDX_W = $clog2(WORD_W),
  localparam int unsigned CNT_W = $clog2(LEN_C + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  rate_e            rate_i,
  output logic             start_o,
  output logic             slot_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o,
  output logic             sig_frm_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

  logic             sync_q, locked_q, slot_q, sig_frm_q;
  logic [1:0]       wcnt_q;
  logic [CNT_W-1:0] cnt_q, frame_len;
  logic [IDX_W-1:0] idx_q;
  logic             rise, fall, self_start, start;

  always_comb begin
    unique case (rate_i)
      RATE_SHORT: frame_len = CNT_W'(LEN_A);
      RATE_EXTRA: frame_len = CNT_W'(LEN_B);
      default:    frame_len = CNT_W'(LEN_C);
    endcase
  end

  assign rise       = sync_i & ~sync_q;
  assign fall       = ~sync_i & sync_q;
  assign self_start = locked_q & (cnt_q >= frame_len - CNT_W'(1));
  // a sync edge inside an open slot is ignored
  assign start      = (rise | self_start) & ~slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 1'b0;
      wcnt_q    <= '0;
      locked_q  <= 1'b0;
      cnt_q     <= '0;
      slot_q    <= 1'b0;
      idx_q     <= '0;
      sig_frm_q <= 1'b0;
    end else begin
      sync_q <= sync_i;
      if (rise)                         wcnt_q <= 2'd1;
      else if (sync_i && wcnt_q != 2'd3) wcnt_q <= wcnt_q + 2'd1;

      if (rise && !slot_q) locked_q <= 1'b1;

      if (start)         cnt_q <= '0;
      else if (locked_q) cnt_q <= cnt_q + CNT_W'(1);

      if (start) begin
        slot_q <= 1'b1;
        idx_q  <= '0;
      end else if (slot_q) begin
        if (idx_q == IDX_LAST) slot_q <= 1'b0;
        else                   idx_q  <= idx_q + IDX_W'(1);
      end

      if (start)                                sig_frm_q <= 1'b0;
      else if (slot_q && fall && wcnt_q == 2'd2) sig_frm_q <= 1'b1;
    end
  end

  assign start_o   = start;
  assign slot_o    = slot_q;
  assign idx_o     = idx_q;
  assign last_o    = slot_q & (idx_q == IDX_LAST);
  assign sig_frm_o = sig_frm_q;
endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned IDX_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              slot_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              sig_frm_i,
  input  logic [WORD_W-1:0] sample_i,
  input  logic              sig_i,
  output logic              data_o
);
  localparam logic [IDX_W-1:0] IDX_PRE = IDX_W'(WORD_W - 2);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(WORD_W - 1);

  logic [WORD_W-1:0] sr_q;
  logic              sig_q, data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      sig_q  <= 1'b0;
      data_q <= 1'b0;
    end else if (start_i) begin
      sr_q   <= sample_i << 1;
      sig_q  <= sig_i;
      data_q <= sample_i[WORD_W-1];
    end else if (slot_i && idx_i != IDX_END) begin
      sr_q   <= sr_q << 1;
      // last bit position is robbed in signaling frames
      data_q <= (idx_i == IDX_PRE && sig_frm_i) ? sig_q : sr_q[WORD_W-1];
    end else begin
      data_q <= 1'b0;
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/pcm_rx_des.sv
module pcm_rx_des #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_i,
  input  logic              last_i,
  input  logic              sig_frm_i,
  input  logic              data_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              sig_o
);
  logic              bit_nq;
  logic [WORD_W-1:0] sr_q, word_q, nxt;
  logic              valid_q, sig_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_nq <= 1'b0;
    else         bit_nq <= data_i;
  end

  assign nxt = {sr_q[WORD_W-2:0], bit_nq};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      sig_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (slot_i) sr_q <= nxt;
      if (last_i) begin
        word_q  <= nxt;
        valid_q <= 1'b1;
        if (sig_frm_i) sig_q <= bit_nq;
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign sig_o   = sig_q;
endmodule

// File: rtl/pcm_sig_port.sv
module pcm_sig_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned LEN_A  = 192,
  parameter int unsigned LEN_B  = 193,
  parameter int unsigned LEN_C  = 256,
  localparam int unsigned IDX_W = $clog2(WORD_W)
) (
  input  logic              tx_clk_i,
  input  logic              tx_rst_ni,
  input  logic              rx_clk_i,
  input  logic              rx_rst_ni,
  input  logic [1:0]        rate_sel_i,
  input  logic              tx_sync_i,
  input  logic [WORD_W-1:0] tx_sample_i,
  input  logic              tx_sig_i,
  output logic              tx_data_o,
  output logic              tx_slot_o,
  input  logic              rx_sync_i,
  input  logic              rx_data_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o,
  output logic              rx_sig_o
);
  rate_e            rate;
  logic             tx_start, tx_slot, tx_last, tx_sig_frm;
  logic [IDX_W-1:0] tx_idx;
  logic             rx_start, rx_slot, rx_last, rx_sig_frm;
  logic [IDX_W-1:0] rx_idx;

  assign rate = rate_e'(rate_sel_i);

  pcm_frame_ctl #(.WORD_W(WORD_W), .LEN_A(LEN_A), .LEN_B(LEN_B), .LEN_C(LEN_C)) u_tx_ctl (
    .clk_i(tx_clk_i), .rst_ni(tx_rst_ni), .sync_i(tx_sync_i), .rate_i(rate),
    .start_o(tx_start), .slot_o(tx_slot), .idx_o(tx_idx), .last_o(tx_last),
    .sig_frm_o(tx_sig_frm)
  );

  pcm_tx_ser #(.WORD_W(WORD_W)) u_tx_ser (
    .clk_i(tx_clk_i), .rst_ni(tx_rst_ni), .start_i(tx_start), .slot_i(tx_slot),
    .idx_i(tx_idx), .sig_frm_i(tx_sig_frm), .sample_i(tx_sample_i), .sig_i(tx_sig_i),
    .data_o(tx_data_o)
  );

  pcm_frame_ctl #(.WORD_W(WORD_W), .LEN_A(LEN_A), .LEN_B(LEN_B), .LEN_C(LEN_C)) u_rx_ctl (
    .clk_i(rx_clk_i), .rst_ni(rx_rst_ni), .sync_i(rx_sync_i), .rate_i(rate),
    .start_o(rx_start), .slot_o(rx_slot), .idx_o(rx_idx), .last_o(rx_last),
    .sig_frm_o(rx_sig_frm)
  );

  pcm_rx_des #(.WORD_W(WORD_W)) u_rx_des (
    .clk_i(rx_clk_i), .rst_ni(rx_rst_ni), .slot_i(rx_slot), .last_i(rx_last),
    .sig_frm_i(rx_sig_frm), .data_i(rx_data_i), .word_o(rx_word_o),
    .valid_o(rx_valid_o), .sig_o(rx_sig_o)
  );

  assign tx_slot_o = tx_slot;
endmodule

// File: rtl/pcm_port_chk.sv
module pcm_port_chk #(
  parameter int unsigned WORD_W = 8
) (
  input logic tx_clk_i,
  input logic tx_rst_ni,
  input logic rx_clk_i,
  input logic rx_rst_ni,
  input logic tx_slot_o,
  input logic tx_data_o,
  input logic rx_valid_o,
  input logic rx_sig_o
);
  logic [7:0] run_q;
  logic       past_ok_q;

  always_ff @(posedge tx_clk_i or negedge tx_rst_ni) begin
    if (!tx_rst_ni)     run_q <= '0;
    else if (tx_slot_o) run_q <= run_q + 8'd1;
    else                run_q <= '0;
  end

  always_ff @(posedge rx_clk_i or negedge rx_rst_ni) begin
    if (!rx_rst_ni) past_ok_q <= 1'b0;
    else            past_ok_q <= 1'b1;
  end

  assert_slot_width_R3: assert property (@(posedge tx_clk_i) disable iff (!tx_rst_ni)
    (!tx_slot_o && run_q != 8'd0) |-> run_q == 8'(WORD_W));

  assert_slot_max_R3: assert property (@(posedge tx_clk_i) disable iff (!tx_rst_ni)
    run_q <= 8'(WORD_W));

  assert_quiet_line_R3: assert property (@(posedge tx_clk_i) disable iff (!tx_rst_ni)
    !tx_slot_o |-> !tx_data_o);

  assert_valid_pulse_R6: assert property (@(posedge rx_clk_i) disable iff (!rx_rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_sig_hold_R7: assert property (@(posedge rx_clk_i) disable iff (!rx_rst_ni)
    (past_ok_q && rx_sig_o != $past(rx_sig_o)) |-> rx_valid_o);
endmodule

bind pcm_sig_port pcm_port_chk #(.WORD_W(WORD_W)) u_chk (
  .tx_clk_i(tx_clk_i), .tx_rst_ni(tx_rst_ni), .rx_clk_i(rx_clk_i), .rx_rst_ni(rx_rst_ni),
  .tx_slot_o(tx_slot_o), .tx_data_o(tx_data_o), .rx_valid_o(rx_valid_o), .rx_sig_o(rx_sig_o)
);

// File: tb/pcm_sig_port_test.sv
module pcm_sig_port_test;
  typedef struct packed {
    logic [7:0] smp;
    logic       sig;
    logic [1:0] w;     // sync width; 0 = no sync
    logic [1:0] rate;
    logic [7:0] ew;    // expected serial / received word
    logic       es;    // expected held signaling bit
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{8'hA5, 1'b0, 2'd1, 2'd0, 8'hA5, 1'b0},
    '{8'hA5, 1'b0, 2'd2, 2'd0, 8'hA4, 1'b0},
    '{8'h3C, 1'b1, 2'd2, 2'd0, 8'h3D, 1'b1},
    '{8'h80, 1'b0, 2'd1, 2'd0, 8'h80, 1'b1},
    '{8'h81, 1'b0, 2'd3, 2'd0, 8'h81, 1'b1},
    '{8'h96, 1'b0, 2'd0, 2'd0, 8'h96, 1'b1},
    '{8'hFF, 1'b0, 2'd2, 2'd0, 8'hFE, 1'b0},
    '{8'h00, 1'b1, 2'd1, 2'd1, 8'h00, 1'b0},
    '{8'h5A, 1'b1, 2'd2, 2'd1, 8'h5B, 1'b1},
    '{8'h0F, 1'b0, 2'd0, 2'd1, 8'h0F, 1'b1},
    '{8'hC3, 1'b0, 2'd1, 2'd2, 8'hC3, 1'b1},
    '{8'h7E, 1'b0, 2'd2, 2'd2, 8'h7E, 1'b0},
    '{8'h02, 1'b1, 2'd3, 2'd2, 8'h02, 1'b0},
    '{8'hFE, 1'b1, 2'd2, 2'd2, 8'hFF, 1'b1},
    '{8'h69, 1'b0, 2'd0, 2'd2, 8'h69, 1'b1},
    '{8'h33, 1'b0, 2'd2, 2'd3, 8'h32, 1'b0},
    '{8'h55, 1'b1, 2'd0, 2'd3, 8'h55, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       sync = 1'b0;
  logic [7:0] sample = 8'h00;
  logic       sig = 1'b0;
  logic       tx_data, tx_slot, rx_valid, rx_sig;
  logic [7:0] rx_word;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  pcm_sig_port uut (
    .tx_clk_i(clk), .tx_rst_ni(rst_n), .rx_clk_i(clk), .rx_rst_ni(rst_n),
    .rate_sel_i(rate_sel), .tx_sync_i(sync), .tx_sample_i(sample), .tx_sig_i(sig),
    .tx_data_o(tx_data), .tx_slot_o(tx_slot),
    .rx_sync_i(sync), .rx_data_i(tx_data),
    .rx_word_o(rx_word), .rx_valid_o(rx_valid), .rx_sig_o(rx_sig)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int flen(input logic [1:0] r);
    return (r == 2'd0) ? 192 : (r == 2'd1) ? 193 : 256;
  endfunction

  task automatic run_frame(input vec_t v, input logic prev_sig);
    logic [7:0] bits = '0;
    int         nslot = 0;
    string      tag;
    tag = (v.w == 2'd0) ? "R9" : (v.w == 2'd2) ? "R5" : (v.w == 2'd3) ? "R4" : "R2";
    rate_sel = v.rate;
    sample   = v.smp;
    sig      = v.sig;
    sync     = (v.w != 2'd0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      bits  = {bits[6:0], tx_data};
      nslot += int'(tx_slot);
      if (i == 0) chk({tag, " slot opens"}, {7'd0, tx_slot}, 8'd1);
      sync = (v.w != 2'd0) && (i + 1 < int'(v.w));
      if (i == 7) begin
        chk("R7 sig held before ninth edge", {7'd0, rx_sig}, {7'd0, prev_sig});
        chk("R6 no early valid", {7'd0, rx_valid}, 8'd0);
      end
    end
    @(negedge clk);
    chk("R3 slot closes", {7'd0, tx_slot}, 8'd0);
    chk("R3 slot width", 8'(nslot), 8'd8);
    chk({tag, " serial word"}, bits, v.ew);
    chk("R6 valid at ninth edge", {7'd0, rx_valid}, 8'd1);
    chk("R6 received word", rx_word, v.ew);
    chk("R7 held sig", {7'd0, rx_sig}, {7'd0, v.es});
    @(negedge clk);
    chk("R6 valid one cycle", {7'd0, rx_valid}, 8'd0);
    repeat (flen(v.rate) - 10) @(negedge clk);
    chk("R8 no early frame", {7'd0, tx_slot}, 8'd0);
  endtask

  task automatic idle_check(input string tag);
    int seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      seen += int'(tx_slot | rx_valid);
    end
    chk(tag, 8'(seen), 8'd0);
  endtask

  initial begin
    logic prev;
    repeat (3) @(negedge clk);
    chk("R1 reset tx_data", {7'd0, tx_data}, 8'd0);
    chk("R1 reset slot", {7'd0, tx_slot}, 8'd0);
    chk("R1 reset word", rx_word, 8'd0);
    chk("R1 reset valid/sig", {6'd0, rx_valid, rx_sig}, 8'd0);
    rst_n = 1'b1;
    idle_check("R1 no frame before sync");

    prev = 1'b0;
    for (int k = 0; k < NV; k++) begin
      run_frame(VEC[k], prev);
      prev = VEC[k].es;
    end

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears sig", {7'd0, rx_sig}, 8'd0);
    rst_n = 1'b1;
    idle_check("R1 no self frame after reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule